// File: doc/BRIEF.md
# Sixteen-Channel Pulse-Division PWM Bank

This block drives sixteen pulse-width-modulated outputs from one shared 8-bit counter. A prescaler can slow the counter clock. Each channel compares its own 8-bit duty value against the counter. The channel's high time is not one long pulse per 256 counts. It is broken into short pulses spread over the whole period, so the output toggles at a much higher rate than one cycle per 256 counts while the average level stays the same.

Software programs the block through a simple write port. The addresses hold:

- the sixteen duty values;
- two polarity bytes and two output-enable bytes, each byte covering eight channels;
- a clock-select code.

A per-channel full-duty input forces a channel to its steady active level. This gives the 100% case, which the comparator alone cannot reach. Duty values and the clock-select code are taken up only when the counter wraps to zero. A period is therefore never produced with mixed settings.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register holds 0, so all sixteen outputs are low even when `full_duty` is asserted.
- R2: With clock-select 0, the counter advances once per clock. A channel that is enabled, non-inverted and not forced is high for exactly `duty` of every 256 consecutive clocks. `pwm_out` is registered and shows the counter value of the previous clock.
- R3: The period is split into 16 sub-periods of 16 counts, where sub-period s covers counts 16*s to 16*s+15. In each sub-period the output is high from the sub-period start for `duty[7:4]` counts. One extra count is added when the bit-reversed value of s is below `duty[3:0]`. For example, duty 0x05 gives single-count pulses at counts 0, 32, 64, 128 and 192.
- R4: The polarity bit of a channel inverts its waveform, so the high count per period becomes 256 minus `duty`. Polarity bit i of channels 0–7 is at address 16, bit i. Channel 8+i uses address 17, bit i.
- R5: A channel whose enable bit is 0 outputs a constant 0, whatever its polarity, duty or `full_duty`. Enable bit i of channels 0–7 is at address 18, bit i. Channel 8+i uses address 19, bit i.
- R6: When `full_duty[i]` is high and channel i is enabled, the output is held at the channel's active level: 1 when non-inverted, 0 when inverted. The duty value has no effect while this holds.
- R7: A duty value written to address i (0–15) is applied only from the next counter wrap to 0. The period in progress finishes with the old value. A write in the same clock as a wrap is taken up at the following wrap.
- R8: Address 20, bits [2:0], select how often the counter advances. Code k from 0 to 4 advances it every 2^k clocks; codes 5 to 7 behave as 4. A new code is applied at the next wrap, so the current period keeps its old length.
- R9: Writes to addresses 21 to 31 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 8 | Write data |
| full_duty | input | 16 | Per-channel force to the active level |
| pwm_out | output | 16 | Registered PWM outputs |

## Verification
The properties assume that every input is synchronous to `clk` and that a write is a single-clock strobe with address and data steady in that clock. They also assume `full_duty` changes only between clock edges. The bench drives every input just after a falling edge and samples outputs on falling edges, which keeps within these assumptions. Channel 15 is kept at duty 1 as a phase marker: its single pulse at count 0 gives the bench the counter phase without looking inside the block. The waveform windows, the mid-period duty write and the clock-select spacing are all measured from that marker.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH    = 16,
  parameter int DW     = 8,
  parameter int SUBW   = 4,
  parameter int SELW   = 3,
  parameter int MAXDIV = 4,
  parameter int AW     = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [NCH-1:0] full_duty,
  output logic [NCH-1:0] pwm_out
);
  localparam int PW       = DW - SUBW;
  localparam int NGRP     = (NCH + DW - 1) / DW;
  localparam int POL_BASE = NCH;
  localparam int EN_BASE  = NCH + NGRP;
  localparam int SEL_ADDR = NCH + 2 * NGRP;

  logic [NCH-1:0][DW-1:0] duty_q, duty_act;
  logic [NCH-1:0]         pol_q, en_q, cmp;
  logic [SELW-1:0]        sel_q, sel_act;
  logic [MAXDIV-1:0]      presc, mask;
  logic [DW-1:0]          cnt;
  logic [SUBW-1:0]        sub_rev;
  logic                   tick, wrap;

  assign mask = (sel_act >= SELW'(MAXDIV)) ? '1 : MAXDIV'((1 << sel_act) - 1);
  assign tick = ((presc & mask) == mask);
  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < NCH; c++)
        if (wr_addr == AW'(c)) duty_q[c] <= wr_data;
      for (int g = 0; g < NGRP; g++) begin
        if (wr_addr == AW'(POL_BASE + g)) pol_q[g*DW +: DW] <= wr_data;
        if (wr_addr == AW'(EN_BASE + g))  en_q[g*DW +: DW]  <= wr_data;
      end
      if (wr_addr == AW'(SEL_ADDR)) sel_q <= wr_data[SELW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc    <= '0;
      cnt      <= '0;
      duty_act <= '0;
      sel_act  <= '0;
    end else if (wrap) begin
      presc    <= '0;
      cnt      <= '0;
      duty_act <= duty_q;
      sel_act  <= sel_q;
    end else begin
      presc <= presc + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  for (genvar b = 0; b < SUBW; b++) begin : g_rev
    assign sub_rev[b] = cnt[DW-1-b];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PW:0] width;
    assign width  = {1'b0, duty_act[c][DW-1:SUBW]}
                  + (PW+1)'(sub_rev < duty_act[c][SUBW-1:0]);
    assign cmp[c] = ({1'b0, cnt[PW-1:0]} < width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= '0;
    else        pwm_out <= en_q & ((full_duty & ~pol_q) | (~full_duty & (cmp ^ pol_q)));
  end
endmodule

module pwm_bank_chk #(
  parameter int NCH  = 16,
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick,
  input logic [DW-1:0]          cnt,
  input logic [NCH-1:0][DW-1:0] duty_act,
  input logic [SELW-1:0]        sel_act,
  input logic [NCH-1:0]         pol_q,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0]         full_duty,
  input logic [NCH-1:0]         pwm_out
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == DW'($past(cnt) + 1'b1)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_duty_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && (&cnt)) |=> $stable(duty_act));

  assert_sel_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && (&cnt)) |=> $stable(sel_act));

  assert_disabled_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pwm_out & ~$past(en_q)) == '0));

  assert_full_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pwm_out ^ ~$past(pol_q)) & $past(full_duty & en_q)) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_zero
    assert_zero_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act[c] == '0 && en_q[c] && !full_duty[c]) |=> (pwm_out[c] == $past(pol_q[c])));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DW(DW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .duty_act(duty_act),
  .sel_act(sel_act), .pol_q(pol_q), .en_q(en_q), .full_duty(full_duty),
  .pwm_out(pwm_out)
);

// File: tb/sim_pwm_bank.sv
`timescale 1ns/1ps
module sim_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] full_duty = '0;
  logic [15:0] pwm_out;

  int checks = 0;
  int errors = 0;
  logic [255:0] win;

  always #10 clk = ~clk;

  pwm_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
               .wr_data(wr_data), .full_duty(full_duty), .pwm_out(pwm_out));

  // {duty, polarity, high count, rising edges}
  localparam logic [25:0] VEC [0:8] = '{
    {8'h00, 1'b0, 9'd0,   8'd0},
    {8'h80, 1'b0, 9'd128, 8'd16},
    {8'h05, 1'b0, 9'd5,   8'd5},
    {8'hFF, 1'b0, 9'd255, 8'd1},
    {8'h11, 1'b0, 9'd17,  8'd16},
    {8'h0F, 1'b0, 9'd15,  8'd15},
    {8'hF0, 1'b0, 9'd240, 8'd16},
    {8'h40, 1'b1, 9'd192, 8'd16},
    {8'h00, 1'b1, 9'd256, 8'd0}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_mark();
    logic prev;
    prev = pwm_out[15];
    forever begin
      @(negedge clk);
      if (!prev && pwm_out[15]) break;
      prev = pwm_out[15];
    end
  endtask

  task automatic capture(int ch, int widx, int wa, int wd);
    for (int i = 0; i < 256; i++) begin
      win[i] = pwm_out[ch];
      if (i == widx) begin wr_en = 1'b1; wr_addr = 5'(wa); wr_data = 8'(wd); end
      if (i == widx + 1) wr_en = 1'b0;
      if (i != 255) @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  function automatic int highs();
    int n = 0;
    for (int i = 0; i < 256; i++) n += int'(win[i]);
    return n;
  endfunction

  function automatic int rises();
    int n = 0;
    for (int i = 0; i < 256; i++) if (win[i] && !win[(i + 255) % 256]) n++;
    return n;
  endfunction

  task automatic gap(int start, output int t);
    logic prev;
    t = start;
    prev = pwm_out[15];
    forever begin
      @(negedge clk);
      t++;
      if (!prev && pwm_out[15]) break;
      prev = pwm_out[15];
    end
  endtask

  task automatic run_all();
    int t;
    logic [255:0] expv;
    int mism;
    full_duty = '1;
    repeat (3) @(negedge clk);
    chk("R1 outputs during reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1 outputs after reset with force high", int'(pwm_out), 0);
    full_duty = '0;

    wr(15, 8'h01);
    wr(19, 8'h80);
    wr(18, 8'h01);
    for (int v = 0; v < 9; v++) begin
      wr(0, int'(VEC[v][25:18]));
      wr(16, int'(VEC[v][17]));
      sync_mark();
      capture(0, 999, 0, 0);
      chk($sformatf("R2/R4 high count duty %0h", VEC[v][25:18]), highs(), int'(VEC[v][16:8]));
      chk($sformatf("R3 rising edges duty %0h", VEC[v][25:18]), rises(), int'(VEC[v][7:0]));
    end

    wr(16, 0);
    wr(0, 8'h05);
    sync_mark();
    capture(0, 999, 0, 0);
    expv = '0;
    expv[0] = 1'b1; expv[32] = 1'b1; expv[64] = 1'b1; expv[128] = 1'b1; expv[192] = 1'b1;
    mism = 0;
    for (int i = 0; i < 256; i++) if (win[i] != expv[i]) mism++;
    chk("R3 spread positions duty 05", mism, 0);
    wr(0, 8'h02);
    sync_mark();
    capture(0, 999, 0, 0);
    chk("R3 pulse at count 0 duty 02", int'(win[0]), 1);
    chk("R3 pulse at count 128 duty 02", int'(win[128]), 1);

    wr(9, 8'h40);
    wr(17, 8'h02);
    wr(19, 8'h82);
    sync_mark();
    capture(9, 999, 0, 0);
    chk("R4 inverted channel 9 high count", highs(), 192);

    wr(1, 8'h80);
    wr(16, 8'h02);
    full_duty = 16'h0002;
    sync_mark();
    capture(1, 999, 0, 0);
    chk("R5 disabled channel 1 high count", highs(), 0);
    full_duty = '0;

    wr(16, 0);
    wr(0, 8'h10);
    full_duty = 16'h0001;
    sync_mark();
    capture(0, 999, 0, 0);
    chk("R6 forced non-inverted high count", highs(), 256);
    wr(16, 1);
    sync_mark();
    capture(0, 999, 0, 0);
    chk("R6 forced inverted high count", highs(), 0);
    full_duty = '0;
    wr(16, 0);

    wr(0, 8'h30);
    for (int a = 21; a < 32; a++) wr(a, 8'hFF);
    sync_mark();
    capture(0, 999, 0, 0);
    chk("R9 channel 0 after stray writes", highs(), 48);
    capture(2, 999, 0, 0);
    chk("R9 channel 2 still disabled", highs(), 0);

    wr(0, 8'h20);
    sync_mark();
    sync_mark();
    capture(0, 100, 0, 8'h90);
    chk("R7 old duty holds to wrap", highs(), 32);
    sync_mark();
    capture(0, 999, 0, 0);
    chk("R7 new duty after wrap", highs(), 144);

    sync_mark();
    wr(20, 1);
    gap(1, t);
    chk("R8 period before code applies", t, 256);
    gap(0, t);
    chk("R8 period at divide by 2", t, 512);
    wr(20, 7);
    gap(1, t);
    chk("R8 divide by 2 kept to wrap", t, 512);
    gap(0, t);
    chk("R8 code 7 acts as divide by 16", t, 4096);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule